// File: doc/BRIEF.md
# Four-Level Nesting Interrupt Controller

This block sits beside a small 8-bit processor core and arbitrates six interrupt sources. The sources are two external pins, two timer overflows, a serial port and a third timer. Software reaches three byte-wide registers through a simple write/read port: an enable register and two priority registers. For every source, one bit from each priority register is combined into a 2-bit level from 0 to 3. The controller keeps a 4-bit in-service mask with one bit per level. From that mask it decides whether the best pending request may interrupt the handler that is currently running.

Whenever the core signals that it can accept an interrupt, the controller picks a winner. The highest level wins, and a fixed polling order settles ties between equal levels. The controller then raises a one-cycle take strobe together with the winner's vector address. It also marks the winner's level as in service and clears the request flag when that source's rule calls for it. A return pulse from the core retires the highest active level, so a handler that was preempted resumes once the handler that interrupted it has returned.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the enable and both priority registers read 0, `take` is low, `flag_clr` is 0, `ext_flag` is 0 and `in_service` is 0.
- R2: A write with `reg_wr_en` high updates the enable register at address 0xA8, the high-priority register at 0xB7 or the low-priority register at 0xB8. `reg_rdata` returns the addressed register combinationally, and any other address reads 0. Enable bit 6 always reads 0. In all three registers, bit i belongs to source i, with index 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial and 5 timer 2.
- R3: A source's level is {high bit, low bit}, giving 0 to 3 with 3 the highest. Among the pending sources, one at the highest level is granted.
- R4: Among pending sources at the same level, the lowest index wins (external 0, timer 0, external 1, timer 1, serial, timer 2).
- R5: A grant decided in a cycle with `core_ready` high raises `take` for exactly one cycle after the next clock edge. `vector` equals 0x03 + 8 × index (0x03, 0x0B, 0x13, 0x1B, 0x23, 0x2B) in that cycle.
- R6: A source is pending only when its request is set, its enable bit is 1 and enable bit 7 (global) is 1.
- R7: A request is not granted while its own level or a higher level is set in `in_service`. It is granted once a return clears that level.
- R8: A request at a level above every set `in_service` bit is granted, and the grant sets `in_service` bit n for level n.
- R9: A one-cycle `reti` pulse clears the highest set bit of `in_service` at the next edge. It has no effect when the mask is 0.
- R10: With `take`, `flag_clr` pulses the winner's bit in these cases: always for timer 0 and timer 1, and for an external source only in transition mode. It stays 0 for serial, for timer 2 and for an external source in level mode.
- R11: With `ext_edge_mode` bit = 1 (transition mode), a high-to-low change of `ext_pin_n` seen on two successive clock samples sets `ext_flag` two edges after the pin falls. The flag stays set after the pin rises and is cleared when that source is taken.
- R12: With `ext_edge_mode` bit = 0 (level mode), `ext_flag` follows the inverted pin two edges later and is not cleared by a take.
- R13: No grant is made in a cycle where `core_ready` is low, `reti` is high or `take` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| ext_pin_n | input | 2 | External request pins, active low (bit 0 = external 0) |
| ext_edge_mode | input | 2 | Per external pin: 1 transition mode, 0 level mode |
| periph_req | input | 4 | Peripheral request flags: timer 0, timer 1, serial, timer 2 (bits 0..3) |
| core_ready | input | 1 | Core can accept an interrupt this cycle |
| reti | input | 1 | Return-from-interrupt pulse |
| take | output | 1 | One-cycle interrupt take strobe |
| vector | output | 8 | Vector address, valid with take |
| flag_clr | output | 6 | Per-source hardware flag clear pulse, by source index |
| ext_flag | output | 2 | Latched external request flags |
| in_service | output | 4 | Bit n set while a level-n handler is active |

## Verification
The assertions rely on three things about the inputs. `ext_edge_mode` does not change while a pin event is still in the sampling stages. `core_ready` and `reti` are single-cycle pulses from a well-behaved core. A timer flag on `periph_req` drops only after the core has seen its `flag_clr` pulse. The stimulus respects all three: it holds the mode inputs for the whole of each test, it drives `core_ready` and `reti` as one-cycle pulses only, and it withdraws a peripheral request by hand after checking its clear strobe. That last step is how a timer block would behave.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int IRQ_NSRC = 6;
    localparam int IRQ_NLVL = 4;
    localparam int IRQ_NEXT = 2;

    typedef enum logic [2:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5
    } irq_src_e;
endpackage

// File: rtl/irq_ext_latch.sv
module irq_ext_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic flag;
    } ext_st_t;

    ext_st_t ext_d, ext_q;

    always_comb begin
        ext_d    = ext_q;
        ext_d.s1 = pin_n;
        ext_d.s2 = ext_q.s1;
        if (edge_mode) begin
            ext_d.flag = (ext_q.s2 & ~ext_q.s1) | (ext_q.flag & ~clr);
        end else begin
            ext_d.flag = ~ext_q.s1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= '{s1: 1'b1, s2: 1'b1, flag: 1'b0};
        end else begin
            ext_q <= ext_d;
        end
    end

    assign flag = ext_q.flag;

    // R11
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && ext_q.s2 && !ext_q.s1) |=> ext_q.flag);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NSRC  = 6,
    parameter int LVL_W = 2,
    parameter int IDX_W = 3
) (
    input  logic [NSRC-1:0]             pending,
    input  logic [NSRC-1:0][LVL_W-1:0]  lvl,
    output logic                        any,
    output logic [IDX_W-1:0]            sel_idx,
    output logic [LVL_W-1:0]            sel_lvl
);
    always_comb begin
        any     = 1'b0;
        sel_idx = '0;
        sel_lvl = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pending[i] && (!any || lvl[i] >= sel_lvl)) begin
                any     = 1'b1;
                sel_idx = IDX_W'(i);
                sel_lvl = lvl[i];
            end
        end
    end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
    parameter int          DW       = 8,
    parameter int          AW       = 8,
    parameter int          NSRC     = irq_pkg::IRQ_NSRC,
    parameter int          NLVL     = irq_pkg::IRQ_NLVL,
    parameter int          NEXT     = irq_pkg::IRQ_NEXT,
    parameter logic [7:0]  ADDR_EN  = 8'hA8,
    parameter logic [7:0]  ADDR_PHI = 8'hB7,
    parameter logic [7:0]  ADDR_PLO = 8'hB8,
    parameter int          EA_BIT   = 7,
    parameter int          VEC_BASE = 3,
    parameter int          VEC_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [NEXT-1:0]  ext_pin_n,
    input  logic [NEXT-1:0]  ext_edge_mode,
    input  logic [NSRC-NEXT-1:0] periph_req,
    input  logic             core_ready,
    input  logic             reti,
    output logic             take,
    output logic [DW-1:0]    vector,
    output logic [NSRC-1:0]  flag_clr,
    output logic [NEXT-1:0]  ext_flag,
    output logic [NLVL-1:0]  in_service
);
    import irq_pkg::*;

    localparam int LVL_W = $clog2(NLVL);
    localparam int IDX_W = $clog2(NSRC);
    localparam logic [DW-1:0] EN_MASK = DW'((1 << NSRC) - 1) | DW'(1 << EA_BIT);

    typedef struct packed {
        logic [DW-1:0]   en;
        logic [NSRC-1:0] phi;
        logic [NSRC-1:0] plo;
        logic [NLVL-1:0] ist;
        logic            take;
        logic [DW-1:0]   vec;
        logic [NSRC-1:0] clr;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    logic [NSRC-1:0]            req;
    logic [NSRC-1:0]            hw_clr;
    logic [NSRC-1:0]            pending;
    logic [NSRC-1:0][LVL_W-1:0] lvl;
    logic                       arb_any;
    logic [IDX_W-1:0]           arb_idx;
    logic [LVL_W-1:0]           arb_lvl;
    logic                       blocked;
    logic                       grant;
    logic [LVL_W-1:0]           top_lvl;

    // external request latches, one per pin, at source index 2*g
    for (genvar g = 0; g < NEXT; g++) begin : g_ext
        localparam int EXT_IDX = 2 * g;
        irq_ext_latch i_ext (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_pin_n[g]),
            .edge_mode (ext_edge_mode[g]),
            .clr       (ctl_d.clr[EXT_IDX]),
            .flag      (ext_flag[g])
        );
    end

    always_comb begin
        req    = '0;
        hw_clr = '0;
        req[int'(SRC_EXT0)]    = ext_flag[0];
        req[int'(SRC_TMR0)]    = periph_req[0];
        req[int'(SRC_EXT1)]    = ext_flag[1];
        req[int'(SRC_TMR1)]    = periph_req[1];
        req[int'(SRC_SER)]     = periph_req[2];
        req[int'(SRC_TMR2)]    = periph_req[3];
        hw_clr[int'(SRC_EXT0)] = ext_edge_mode[0];
        hw_clr[int'(SRC_TMR0)] = 1'b1;
        hw_clr[int'(SRC_EXT1)] = ext_edge_mode[1];
        hw_clr[int'(SRC_TMR1)] = 1'b1;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_lvl
        assign lvl[s] = LVL_W'({ctl_q.phi[s], ctl_q.plo[s]});
    end

    assign pending = req & ctl_q.en[NSRC-1:0] & {NSRC{ctl_q.en[EA_BIT]}};

    irq_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) i_arb (
        .pending (pending),
        .lvl     (lvl),
        .any     (arb_any),
        .sel_idx (arb_idx),
        .sel_lvl (arb_lvl)
    );

    assign blocked = |(ctl_q.ist >> arb_lvl);
    assign grant   = arb_any && !blocked && core_ready && !reti && !ctl_q.take;

    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (ctl_q.ist[i]) top_lvl = LVL_W'(i);
        end
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.take = 1'b0;
        ctl_d.clr  = '0;
        if (reg_wr_en) begin
            case (reg_addr)
                ADDR_EN:  ctl_d.en  = reg_wdata & EN_MASK;
                ADDR_PHI: ctl_d.phi = reg_wdata[NSRC-1:0];
                ADDR_PLO: ctl_d.plo = reg_wdata[NSRC-1:0];
                default:  ;
            endcase
        end
        if (reti && |ctl_q.ist) begin
            ctl_d.ist[top_lvl] = 1'b0;
        end
        if (grant) begin
            ctl_d.take         = 1'b1;
            ctl_d.vec          = DW'(VEC_BASE) + DW'(arb_idx) * DW'(VEC_STEP);
            ctl_d.ist[arb_lvl] = 1'b1;
            ctl_d.clr          = hw_clr & (NSRC'(1) << arb_idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_EN:  reg_rdata = ctl_q.en;
            ADDR_PHI: reg_rdata = DW'(ctl_q.phi);
            ADDR_PLO: reg_rdata = DW'(ctl_q.plo);
            default:  reg_rdata = '0;
        endcase
    end

    assign take       = ctl_q.take;
    assign vector     = ctl_q.vec;
    assign flag_clr   = ctl_q.clr;
    assign in_service = ctl_q.ist;

    // R3
    win_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_any |-> pending[arb_idx]);
    // R13
    take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);
    // R13
    take_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(core_ready) && !$past(reti));
    // R5
    vector_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> vector[2:0] == 3'b011);
    // R8
    nest_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $countones(in_service) == $countones($past(in_service)) + 1);
    // R9
    reti_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> $countones(in_service) + ((|$past(in_service)) ? 1 : 0)
                 == $countones($past(in_service)));
    // R10
    clr_with_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_clr) |-> take && $onehot0(flag_clr));
endmodule

// File: tb/test_irq_nest_ctrl.sv
module test_irq_nest_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] ext_pin_n = 2'b11;
    logic [1:0] ext_edge_mode = 2'b00;
    logic [3:0] periph_req = 4'b0000;
    logic       core_ready = 1'b0;
    logic       reti = 1'b0;
    logic       take;
    logic [7:0] vector;
    logic [5:0] flag_clr;
    logic [1:0] ext_flag;
    logic [3:0] in_service;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    irq_nest_ctrl i_irq_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin_n(ext_pin_n),
        .ext_edge_mode(ext_edge_mode), .periph_req(periph_req),
        .core_ready(core_ready), .reti(reti), .take(take), .vector(vector),
        .flag_clr(flag_clr), .ext_flag(ext_flag), .in_service(in_service)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic ready_chk(input bit exp_take, input logic [7:0] exp_vec,
                             input logic [5:0] exp_clr, input logic [3:0] exp_ist,
                             input string req);
        core_ready = 1'b1;
        @(negedge clk);
        core_ready = 1'b0;
        chk(take == exp_take, {req, " take"}, take, exp_take);
        if (exp_take) begin
            chk(vector == exp_vec, {req, " vector"}, vector, exp_vec);
            chk(flag_clr == exp_clr, {req, " flag_clr"}, flag_clr, exp_clr);
        end
        chk(in_service == exp_ist, {req, " in_service"}, in_service, exp_ist);
        @(negedge clk);
    endtask

    task automatic do_reti(input logic [3:0] exp_ist, input string req);
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
        chk(in_service == exp_ist, req, in_service, exp_ist);
    endtask

    task automatic t_reset;
        chk(take == 1'b0, "R1 take", take, 0);
        chk(in_service == 4'h0, "R1 in_service", in_service, 0);
        chk(flag_clr == 6'h0 && ext_flag == 2'h0, "R1 flags", {flag_clr, ext_flag}, 0);
        rd_chk(8'hA8, 8'h00, "R1 enable");
        rd_chk(8'hB7, 8'h00, "R1 prio hi");
        rd_chk(8'hB8, 8'h00, "R1 prio lo");
    endtask

    task automatic t_regs;
        wr(8'hA8, 8'hFF); rd_chk(8'hA8, 8'hBF, "R2 enable bit6");
        wr(8'hB7, 8'h2A); rd_chk(8'hB7, 8'h2A, "R2 prio hi");
        wr(8'hB8, 8'h15); rd_chk(8'hB8, 8'h15, "R2 prio lo");
        wr(8'hB9, 8'h55); rd_chk(8'hB9, 8'h00, "R2 unmapped");
        rd_chk(8'hB8, 8'h15, "R2 unmapped write ignored");
        wr(8'hB7, 8'h00); wr(8'hB8, 8'h00); wr(8'hA8, 8'h00);
    endtask

    task automatic t_enable;
        periph_req = 4'b0010;            // timer 1
        wr(8'hA8, 8'h3F);                // global off
        ready_chk(1'b0, 8'h00, 6'h00, 4'h0, "R6 global off");
        wr(8'hA8, 8'h80 | 8'h37);        // timer 1 enable (bit3) off
        ready_chk(1'b0, 8'h00, 6'h00, 4'h0, "R6 source off");
        wr(8'hA8, 8'h88);
        ready_chk(1'b1, 8'h1B, 6'h08, 4'h1, "R6 enabled");
        periph_req = 4'b0000;
        do_reti(4'h0, "R9 return");
        do_reti(4'h0, "R9 empty return");
    endtask

    task automatic t_polling;
        wr(8'hA8, 8'hBF);
        periph_req = 4'b1110;            // timer 1, serial, timer 2
        ready_chk(1'b1, 8'h1B, 6'h08, 4'h1, "R4 timer1 first");
        periph_req = 4'b1100;
        do_reti(4'h0, "R9 poll");
        ready_chk(1'b1, 8'h23, 6'h00, 4'h1, "R4 serial next R10");
        periph_req = 4'b1000;
        do_reti(4'h0, "R9 poll");
        ready_chk(1'b1, 8'h2B, 6'h00, 4'h1, "R5 timer2 vector R10");
        periph_req = 4'b1001;
        do_reti(4'h0, "R9 poll");
        ready_chk(1'b1, 8'h0B, 6'h02, 4'h1, "R4 timer0 before timer2");
        periph_req = 4'b0000;
        do_reti(4'h0, "R9 poll");
    endtask

    task automatic t_levels;
        wr(8'hB7, 8'h10); wr(8'hB8, 8'h12);   // serial lvl3, timer0 lvl1
        periph_req = 4'b0111;
        ready_chk(1'b1, 8'h23, 6'h00, 4'h8, "R3 level3 wins");
        periph_req = 4'b0011;
        do_reti(4'h0, "R9 lvl");
        ready_chk(1'b1, 8'h0B, 6'h02, 4'h2, "R3 level1 over level0");
        periph_req = 4'b0010;
        do_reti(4'h0, "R9 lvl");
        ready_chk(1'b1, 8'h1B, 6'h08, 4'h1, "R8 level0 sets bit0");
        periph_req = 4'b0000;
        do_reti(4'h0, "R9 lvl");
        wr(8'hB7, 8'h00); wr(8'hB8, 8'h00);
    endtask

    task automatic t_nesting;
        wr(8'hB7, 8'h02); wr(8'hB8, 8'h20);   // timer0 lvl2, timer2 lvl1
        periph_req = 4'b1000;
        ready_chk(1'b1, 8'h2B, 6'h00, 4'h2, "R8 timer2 level1");
        ready_chk(1'b0, 8'h00, 6'h00, 4'h2, "R7 same level waits");
        periph_req = 4'b1100;
        ready_chk(1'b0, 8'h00, 6'h00, 4'h2, "R7 lower level waits");
        periph_req = 4'b1001;
        ready_chk(1'b1, 8'h0B, 6'h02, 4'h6, "R8 preempt level2");
        periph_req = 4'b1000;
        do_reti(4'h2, "R9 top cleared");
        ready_chk(1'b0, 8'h00, 6'h00, 4'h2, "R7 resumed level blocks");
        do_reti(4'h0, "R9 last cleared");
        ready_chk(1'b1, 8'h2B, 6'h00, 4'h2, "R7 granted after return");
        periph_req = 4'b0000;
        do_reti(4'h0, "R9 nest end");
        wr(8'hB7, 8'h00); wr(8'hB8, 8'h00);
    endtask

    task automatic t_ext_edge;
        ext_edge_mode = 2'b01;
        wr(8'hA8, 8'h81);
        ext_pin_n[0] = 1'b0;
        @(negedge clk);
        chk(ext_flag[0] == 1'b0, "R11 not yet", ext_flag[0], 0);
        @(negedge clk);
        chk(ext_flag[0] == 1'b1, "R11 edge latched", ext_flag[0], 1);
        ext_pin_n[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk(ext_flag[0] == 1'b1, "R11 held after rise", ext_flag[0], 1);
        ready_chk(1'b1, 8'h03, 6'h01, 4'h1, "R10 ext0 transition");
        chk(ext_flag[0] == 1'b0, "R11 cleared by take", ext_flag[0], 0);
        do_reti(4'h0, "R9 ext");
        ready_chk(1'b0, 8'h00, 6'h00, 4'h0, "R11 no re-trigger");
    endtask

    task automatic t_ext_level;
        ext_edge_mode = 2'b00;
        wr(8'hA8, 8'h84);
        ext_pin_n[1] = 1'b0;
        repeat (2) @(negedge clk);
        chk(ext_flag[1] == 1'b1, "R12 follows pin", ext_flag[1], 1);
        ready_chk(1'b1, 8'h13, 6'h00, 4'h1, "R10 ext1 level no clear");
        chk(ext_flag[1] == 1'b1, "R12 not cleared", ext_flag[1], 1);
        ext_pin_n[1] = 1'b1;
        repeat (2) @(negedge clk);
        chk(ext_flag[1] == 1'b0, "R12 drops with pin", ext_flag[1], 0);
        do_reti(4'h0, "R9 ext level");
    endtask

    task automatic t_ready;
        wr(8'hA8, 8'h82);
        periph_req = 4'b0001;
        repeat (3) @(negedge clk);
        chk(take == 1'b0, "R13 ready low", take, 0);
        reti = 1'b1; core_ready = 1'b1;
        @(negedge clk);
        reti = 1'b0; core_ready = 1'b0;
        chk(take == 1'b0, "R13 reti blocks", take, 0);
        @(negedge clk);
        ready_chk(1'b1, 8'h0B, 6'h02, 4'h1, "R13 then granted");
        periph_req = 4'b0000;
        do_reti(4'h0, "R9 ready");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_enable();
        t_polling();
        t_levels();
        t_nesting();
        t_ext_edge();
        t_ext_level();
        t_ready();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule